// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 20-bit effective address of a memory operand from the fields of an instruction that has already been decoded. A 3-bit mode code picks how the address is built:
- the operand word joined to a bank field;
- an index register with its 4-bit bank, plus an 8-bit, 16-bit or 20-bit offset;
- an index register with its bank, plus accumulator E;
- the address that follows the current opcode word;
- no memory operand at all.

All sums are 20 bits wide. A carry or borrow across a 64 Kbyte bank therefore changes the four bank bits of the result.

The result is registered. It appears one clock after a request cycle, together with a valid strobe that is high only for modes that touch memory. In the same cycle the block also registers the 16-bit sign extension of the 8-bit offset field, which the short immediate add instructions use. Decode, the memory access itself, and any write-back to registers or bank fields are outside this block.

Top module: `eag`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `ea_o` = 0, `ea_vld_o` = 0 and `imm_sx_o` = 0.
- R2: Mode 3'b000 (extended) gives `ea_o` = {`ek_i`, `ofs16_i`}. The index registers have no effect in this mode.
- R3: Mode 3'b001 (short indexed) gives `ea_o` = ({bank, index} + zero-extended `ofs8_i`) mod 2^20. An offset of 8'hFF adds 255.
- R4: Mode 3'b010 (word indexed) gives `ea_o` = ({bank, index} + sign-extended `ofs16_i`) mod 2^20.
- R5: Mode 3'b011 (long indexed) gives `ea_o` = ({bank, index} + `ofs20_i`) mod 2^20. This is the mode used for jump and call targets.
- R6: Mode 3'b100 (accumulator offset) gives `ea_o` = ({bank, index} + zero-extended `acc_e_i`) mod 2^20.
- R7: Mode 3'b101 (immediate) gives `ea_o` = (`pc_i` + 2) mod 2^20. Here `pc_i` is the address of the opcode word, so the result is the first byte after it.
- R8: Modes 3'b110 (inherent) and 3'b111 (reserved) give `ea_vld_o` = 0 on the next cycle and leave `ea_o` unchanged.
- R9: The index register follows `idx_sel_i`: 2'b00 selects X with bank `xk_i`, 2'b01 selects Y with `yk_i`, 2'b10 selects Z with `zk_i`, and 2'b11 is treated as X.
- R10: When an indexed or immediate sum carries or borrows across a 64 Kbyte boundary, bits 19:16 of `ea_o` differ from the bank field of the base by that carry or borrow.
- R11: On a request cycle, `imm_sx_o` takes the 8-bit `ofs8_i` sign-extended to 16 bits, one cycle later.
- R12: Results appear on the cycle after `req_i` is high. In a cycle that follows one without a request, `ea_vld_o` is 0 and `ea_o` and `imm_sx_o` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Compute an address this cycle |
| mode_i | input | 3 | Addressing mode code (see R2 to R8) |
| idx_sel_i | input | 2 | Index register select (see R9) |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| iz_i | input | 16 | Index register Z |
| xk_i | input | 4 | Bank field of X |
| yk_i | input | 4 | Bank field of Y |
| zk_i | input | 4 | Bank field of Z |
| ek_i | input | 4 | Bank field for the extended mode |
| acc_e_i | input | 16 | Accumulator E |
| pc_i | input | 20 | Address of the current opcode word |
| ofs8_i | input | 8 | Short offset or short immediate |
| ofs16_i | input | 16 | Word offset or extended address word |
| ofs20_i | input | 20 | Long signed offset |
| ea_o | output | 20 | Registered effective address |
| ea_vld_o | output | 1 | Effective address names a memory operand |
| imm_sx_o | output | 16 | Registered sign extension of `ofs8_i` |

## Verification
The index registers are preloaded so that X sits 16 bytes below a bank top, Y sits just above address zero and Z sits in the top bank. With these bases, small offsets produce carries into the bank bits, borrows out of them, and wraps of the full 20-bit space.

The offset values 8'hFF, 16'hFFE0 and 20'hFFFFF are chosen so that a wrong choice between zero and sign extension produces a visibly different address. An accumulator value of 16'h8000 does the same for the accumulator mode. The three selected bases are distinct, so every select code can be told apart, including the reserved one.

Inherent, reserved and idle cycles follow a known address, so that a held or a changed `ea_o` can be seen.

// File: rtl/eag_pkg.sv
// Package eag_pkg: shared codes for the effective address generator.
// Assumes a 3-bit mode code and a 2-bit index select, as given in the brief.
package eag_pkg;
    typedef enum logic [2:0] {
        AM_EXT   = 3'd0,
        AM_IDX8  = 3'd1,
        AM_IDX16 = 3'd2,
        AM_IDX20 = 3'd3,
        AM_ACCE  = 3'd4,
        AM_IMM   = 3'd5,
        AM_INH   = 3'd6,
        AM_RSV   = 3'd7
    } amode_e;

    localparam logic [1:0] SEL_X = 2'b00;
    localparam logic [1:0] SEL_Y = 2'b01;
    localparam logic [1:0] SEL_Z = 2'b10;
endpackage

// File: rtl/eag_sext.sv
// Module eag_sext: sign-extends an IN_W-bit value to OUT_W bits.
// Assumes OUT_W >= IN_W.
module eag_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    localparam int PAD_W = OUT_W - IN_W;

    // Fill the upper bits with copies of the sign bit.
    always_comb begin
        val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end
endmodule

// File: rtl/eag_index_mux.sv
// Module eag_index_mux: picks one index register and joins it to its bank field.
// Assumes that the reserved select code falls back to X.
module eag_index_mux
    import eag_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int BK_W = 4,
    localparam int AW  = LO_W + BK_W
) (
    input  logic [1:0]      sel_i,
    input  logic [LO_W-1:0] ix_i,
    input  logic [LO_W-1:0] iy_i,
    input  logic [LO_W-1:0] iz_i,
    input  logic [BK_W-1:0] xk_i,
    input  logic [BK_W-1:0] yk_i,
    input  logic [BK_W-1:0] zk_i,
    output logic [AW-1:0]   base_o
);
    // Select the banked base for the chosen index register.
    always_comb begin
        unique case (sel_i)
            SEL_Y:   base_o = {yk_i, iy_i};
            SEL_Z:   base_o = {zk_i, iz_i};
            default: base_o = {xk_i, ix_i};
        endcase
    end
endmodule

// File: rtl/eag_operand_sel.sv
// Module eag_operand_sel: chooses the two addends and the memory flag per mode.
// Assumes the offsets arrive already sign-extended where the mode is signed.
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int LO_W    = 16,
    parameter int BK_W    = 4,
    parameter int SH_W    = 8,
    parameter int PC_STEP = 2,
    localparam int AW     = LO_W + BK_W
) (
    input  logic [2:0]      mode_i,
    input  logic [AW-1:0]   base_i,
    input  logic [BK_W-1:0] ek_i,
    input  logic [SH_W-1:0] ofs8_i,
    input  logic [LO_W-1:0] ofs16_i,
    input  logic [AW-1:0]   ofs16_sx_i,
    input  logic [AW-1:0]   ofs20_i,
    input  logic [LO_W-1:0] acc_e_i,
    input  logic [AW-1:0]   pc_i,
    output logic [AW-1:0]   opa_o,
    output logic [AW-1:0]   opb_o,
    output logic            mem_o
);
    // Route base and offset to the adder according to the mode code.
    always_comb begin
        opa_o = base_i;
        opb_o = '0;
        mem_o = 1'b1;
        unique case (amode_e'(mode_i))
            AM_EXT:   opa_o = {ek_i, ofs16_i};
            AM_IDX8:  opb_o = {{(AW-SH_W){1'b0}}, ofs8_i};
            AM_IDX16: opb_o = ofs16_sx_i;
            AM_IDX20: opb_o = ofs20_i;
            AM_ACCE:  opb_o = {{BK_W{1'b0}}, acc_e_i};
            AM_IMM: begin
                opa_o = pc_i;
                opb_o = AW'(PC_STEP);
            end
            default: begin
                opa_o = '0;
                mem_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eag_bank_adder.sv
// Module eag_bank_adder: full-width sum of base and offset, wrapping at 2^AW.
// Assumes a carry out of the low part is meant to move the bank bits.
module eag_bank_adder #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] opa_i,
    input  logic [AW-1:0] opb_i,
    output logic [AW-1:0] sum_o
);
    // One adder over bank and low bits together, with the top carry dropped.
    always_comb begin
        sum_o = opa_i + opb_i;
    end
endmodule

// File: rtl/eag.sv
// Module eag: registered banked effective address generator (top).
// Assumes the mode and the fields are valid during the cycle in which req_i is high.
// Results appear one clock later. The outputs hold when no request is made.
module eag
    import eag_pkg::*;
#(
    parameter int LO_W    = 16,
    parameter int BK_W    = 4,
    parameter int SH_W    = 8,
    parameter int PC_STEP = 2,
    localparam int AW     = LO_W + BK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [2:0]      mode_i,
    input  logic [1:0]      idx_sel_i,
    input  logic [LO_W-1:0] ix_i,
    input  logic [LO_W-1:0] iy_i,
    input  logic [LO_W-1:0] iz_i,
    input  logic [BK_W-1:0] xk_i,
    input  logic [BK_W-1:0] yk_i,
    input  logic [BK_W-1:0] zk_i,
    input  logic [BK_W-1:0] ek_i,
    input  logic [LO_W-1:0] acc_e_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [SH_W-1:0] ofs8_i,
    input  logic [LO_W-1:0] ofs16_i,
    input  logic [AW-1:0]   ofs20_i,
    output logic [AW-1:0]   ea_o,
    output logic            ea_vld_o,
    output logic [LO_W-1:0] imm_sx_o
);
    logic [AW-1:0]   base;
    logic [AW-1:0]   ofs16_sx;
    logic [LO_W-1:0] imm_sx;
    logic [AW-1:0]   opa;
    logic [AW-1:0]   opb;
    logic [AW-1:0]   sum;
    logic            mem_op;

    eag_index_mux #(.LO_W(LO_W), .BK_W(BK_W)) u_idx (
        .sel_i (idx_sel_i),
        .ix_i  (ix_i),
        .iy_i  (iy_i),
        .iz_i  (iz_i),
        .xk_i  (xk_i),
        .yk_i  (yk_i),
        .zk_i  (zk_i),
        .base_o(base)
    );

    eag_sext #(.IN_W(LO_W), .OUT_W(AW)) u_sx_word (
        .val_i(ofs16_i),
        .val_o(ofs16_sx)
    );

    eag_sext #(.IN_W(SH_W), .OUT_W(LO_W)) u_sx_imm (
        .val_i(ofs8_i),
        .val_o(imm_sx)
    );

    eag_operand_sel #(
        .LO_W(LO_W), .BK_W(BK_W), .SH_W(SH_W), .PC_STEP(PC_STEP)
    ) u_ops (
        .mode_i    (mode_i),
        .base_i    (base),
        .ek_i      (ek_i),
        .ofs8_i    (ofs8_i),
        .ofs16_i   (ofs16_i),
        .ofs16_sx_i(ofs16_sx),
        .ofs20_i   (ofs20_i),
        .acc_e_i   (acc_e_i),
        .pc_i      (pc_i),
        .opa_o     (opa),
        .opb_o     (opb),
        .mem_o     (mem_op)
    );

    eag_bank_adder #(.AW(AW)) u_add (
        .opa_i(opa),
        .opb_i(opb),
        .sum_o(sum)
    );

    // Register the address, the strobe and the short immediate on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o     <= '0;
            ea_vld_o <= 1'b0;
            imm_sx_o <= '0;
        end else begin
            ea_vld_o <= req_i & mem_op;
            if (req_i) begin
                imm_sx_o <= imm_sx;
                if (mem_op) begin
                    ea_o <= sum;
                end
            end
        end
    end
endmodule

// File: rtl/eag_chk.sv
// Module eag_chk: timing and port-level checks for eag, attached through bind.
// Assumes default parameters: a 20-bit address, 4-bit banks and an opcode step of 2.
module eag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [2:0]  mode_i,
    input logic [3:0]  ek_i,
    input logic [15:0] ofs16_i,
    input logic [7:0]  ofs8_i,
    input logic [19:0] pc_i,
    input logic [19:0] ea_o,
    input logic        ea_vld_o,
    input logic [15:0] imm_sx_o
);
    // Reset clears every output on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ea_o == 20'h0 && !ea_vld_o && imm_sx_o == 16'h0));

    // Extended mode joins the bank field to the operand word.
    assert_ext_concat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 3'd0) |=> (ea_vld_o && ea_o == {$past(ek_i), $past(ofs16_i)}));

    // Immediate mode points past the opcode word.
    assert_imm_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 3'd5) |=> (ea_o == 20'($past(pc_i) + 20'd2)));

    // Inherent and reserved modes drop the strobe and hold the address.
    assert_inherent_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i[2:1] == 2'b11) |=> (!ea_vld_o && $stable(ea_o)));

    // The short immediate is sign-extended one cycle after the request.
    assert_short_sext_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (imm_sx_o == {{8{$past(ofs8_i[7])}}, $past(ofs8_i)}));

    // With no request, the strobe stays low and the results hold.
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!ea_vld_o && $stable(ea_o) && $stable(imm_sx_o)));
endmodule

bind eag eag_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .mode_i  (mode_i),
    .ek_i    (ek_i),
    .ofs16_i (ofs16_i),
    .ofs8_i  (ofs8_i),
    .pc_i    (pc_i),
    .ea_o    (ea_o),
    .ea_vld_o(ea_vld_o),
    .imm_sx_o(imm_sx_o)
);

// File: tb/eag_tb.sv
module eag_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [2:0]  mode_i;
    logic [1:0]  idx_sel_i;
    logic [15:0] ix_i, iy_i, iz_i, acc_e_i, ofs16_i;
    logic [3:0]  xk_i, yk_i, zk_i, ek_i;
    logic [19:0] pc_i, ofs20_i, ea_o;
    logic [7:0]  ofs8_i;
    logic        ea_vld_o;
    logic [15:0] imm_sx_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag u_dut (.*);

    typedef struct packed {
        logic [2:0]  m;
        logic [1:0]  s;
        logic [7:0]  o8;
        logic [15:0] o16;
        logic [19:0] o20;
        logic [19:0] ea;
        logic [15:0] sx;
    } vec_t;

    // Bases: X = 3_FFF0, Y = 0_0010, Z = F_8000, ek = 7, E = 0020, pc = F_FFFF.
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd0, 8'h80, 16'h1234, 20'h0,     20'h71234, 16'hFF80}, // R2 R11
        '{3'd1, 2'd0, 8'h20, 16'h0,    20'h0,     20'h40010, 16'h0020}, // R3 R10 carry
        '{3'd1, 2'd0, 8'hFF, 16'h0,    20'h0,     20'h400EF, 16'hFFFF}, // R3 unsigned
        '{3'd2, 2'd1, 8'h7F, 16'hFFF0, 20'h0,     20'h00000, 16'h007F}, // R4
        '{3'd2, 2'd1, 8'h00, 16'hFFE0, 20'h0,     20'hFFFF0, 16'h0000}, // R4 R10 borrow
        '{3'd2, 2'd2, 8'h00, 16'h7FFF, 20'h0,     20'hFFFFF, 16'h0000}, // R4
        '{3'd3, 2'd2, 8'h00, 16'h0,    20'h08000, 20'h00000, 16'h0000}, // R5 wrap
        '{3'd3, 2'd0, 8'h00, 16'h0,    20'hFFFFF, 20'h3FFEF, 16'h0000}, // R5 negative
        '{3'd4, 2'd0, 8'h00, 16'h0,    20'h0,     20'h40010, 16'h0000}, // R6 R10
        '{3'd5, 2'd0, 8'h00, 16'h0,    20'h0,     20'h00001, 16'h0000}, // R7 wrap
        '{3'd1, 2'd3, 8'h00, 16'h0,    20'h0,     20'h3FFF0, 16'h0000}, // R9 code 11
        '{3'd1, 2'd1, 8'h00, 16'h0,    20'h0,     20'h00010, 16'h0000}, // R9 code 01
        '{3'd1, 2'd2, 8'h01, 16'h0,    20'h0,     20'hF8001, 16'h0001}  // R9 code 10
    };
    localparam int TAG [NV] = '{2, 3, 3, 4, 10, 4, 5, 5, 6, 7, 9, 9, 9};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge, then sample one clock later.
    task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [7:0] o8,
                         input logic [15:0] o16, input logic [19:0] o20, input logic rq);
        @(negedge clk);
        req_i = rq; mode_i = m; idx_sel_i = s;
        ofs8_i = o8; ofs16_i = o16; ofs20_i = o20;
        @(posedge clk);
        #1;
        req_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; mode_i = 3'd0; idx_sel_i = 2'd0;
        ix_i = 16'hFFF0; xk_i = 4'h3;
        iy_i = 16'h0010; yk_i = 4'h0;
        iz_i = 16'h8000; zk_i = 4'hF;
        ek_i = 4'h7; acc_e_i = 16'h0020; pc_i = 20'hFFFFF;
        ofs8_i = 8'h0; ofs16_i = 16'h0; ofs20_i = 20'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 ea", 32'(ea_o), 32'h0);
        check("R1 vld", 32'(ea_vld_o), 32'h0);
        check("R1 sx", 32'(imm_sx_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: address, strobe and short sign extension.
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].m, TBL[i].s, TBL[i].o8, TBL[i].o16, TBL[i].o20, 1'b1);
            check($sformatf("R%0d vec%0d ea", TAG[i], i), 32'(ea_o), 32'(TBL[i].ea));
            check($sformatf("R%0d vec%0d vld", TAG[i], i), 32'(ea_vld_o), 32'h1);
            check($sformatf("R11 vec%0d sx", i), 32'(imm_sx_o), 32'(TBL[i].sx));
        end

        // R2 extended mode ignores the index registers.
        ix_i = 16'h5555; xk_i = 4'hA;
        issue(3'd0, 2'd0, 8'h00, 16'hBEEF, 20'h0, 1'b1);
        check("R2 index ignored", 32'(ea_o), 32'h7BEEF);
        ix_i = 16'hFFF0; xk_i = 4'h3;

        // R6 accumulator E is unsigned: 3_FFF0 + 8000 = 4_7FF0.
        acc_e_i = 16'h8000;
        issue(3'd4, 2'd0, 8'h00, 16'h0, 20'h0, 1'b1);
        check("R6 E unsigned", 32'(ea_o), 32'h47FF0);

        // R8 inherent and reserved: strobe low, address held at 4_7FF0.
        issue(3'd6, 2'd1, 8'h00, 16'h0, 20'h0, 1'b1);
        check("R8 inh vld", 32'(ea_vld_o), 32'h0);
        check("R8 inh ea", 32'(ea_o), 32'h47FF0);
        issue(3'd7, 2'd2, 8'h00, 16'h0, 20'h0, 1'b1);
        check("R8 rsv vld", 32'(ea_vld_o), 32'h0);
        check("R8 rsv ea", 32'(ea_o), 32'h47FF0);

        // R12 no request: fields change, outputs hold and the strobe stays low.
        issue(3'd1, 2'd1, 8'hC3, 16'h0, 20'h0, 1'b0);
        check("R12 idle vld", 32'(ea_vld_o), 32'h0);
        check("R12 idle ea", 32'(ea_o), 32'h47FF0);
        check("R12 idle sx", 32'(imm_sx_o), 32'h0);

        // R12 latency: the result is absent at the request edge and present one edge later.
        @(negedge clk);
        req_i = 1'b1; mode_i = 3'd1; idx_sel_i = 2'd1; ofs8_i = 8'h05;
        #1;
        check("R12 before edge", 32'(ea_o), 32'h47FF0);
        @(posedge clk);
        #1;
        req_i = 1'b0;
        check("R12 after edge", 32'(ea_o), 32'h00015);

        // R1 reset in mid-run clears the outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid ea", 32'(ea_o), 32'h0);
        check("R1 mid sx", 32'(imm_sx_o), 32'h0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule